// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block connects two data ports, A and B, of a configurable width. Each direction has its own storage stage and three controls: a pass enable, a capture strobe and a drive enable. While the pass enable is high, the stage is transparent, so the far port follows the near port. While the pass enable is low, the stage holds its value and loads new data only on a rising edge of the capture strobe. The A-to-B and B-to-A directions are fully independent.

The whole block runs on one system clock. All control inputs go through a synchronizer before use, and strobe edges are found by comparing successive synchronized samples. Tri-state pins are modelled as a data output and a drive-enable output per port. Each input port also has a driven flag. An optional keeper on each input gives the storage stage the last actively driven value whenever the external bus is left floating.

Top module: `bus_xcvr`

## Requirements
- R1: While rst_n is low, every output reads 0 at the next clock edge: both data outputs and both drive enables. No control input overrides reset.
- R2: When a direction's pass enable is high, its output equals its effective input one clock after the synchronized enable. Controls take SYNC_STAGES clocks to arrive.
- R3: When the pass enable is low and the strobe does not change level, the output holds its value whatever the input does.
- R4: When the pass enable is low, a synchronized 0-to-1 change of the strobe loads the effective input. A 1-to-0 change loads nothing.
- R5: When the pass enable falls, the stage keeps the last value it passed through.
- R6: While the pass enable is high, a strobe edge has no further effect: the output keeps following the input.
- R7: A port's drive enable output equals its direction's synchronized drive-enable control, delayed by one register. The output value does not depend on the drive enable.
- R8: Controls and data of one direction have no effect on the other direction's stored value or drive enable.
- R9: With KEEPER=1 and the driven flag low, the effective input of a port is the last value seen while the flag was high. With KEEPER=0, the effective input is 0 while the flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | WIDTH | Value seen on the A bus |
| a_driven | input | 1 | High when an external driver is on the A bus |
| a_out | output | WIDTH | Value the block presents to the A bus |
| a_drive | output | 1 | High when the block drives the A bus |
| b_in | input | WIDTH | Value seen on the B bus |
| b_driven | input | 1 | High when an external driver is on the B bus |
| b_out | output | WIDTH | Value the block presents to the B bus |
| b_drive | output | 1 | High when the block drives the B bus |
| ab_oe | input | 1 | A-to-B drive enable (drives B) |
| ab_le | input | 1 | A-to-B pass enable |
| ab_stb | input | 1 | A-to-B capture strobe |
| ba_oe | input | 1 | B-to-A drive enable (drives A) |
| ba_le | input | 1 | B-to-A pass enable |
| ba_stb | input | 1 | B-to-A capture strobe |

## Verification
The bench sweeps each direction through pass, hold and capture over several data patterns. It targets these corner cases:
- A strobe pulse during pass mode must change nothing. A design that let the strobe win would freeze the output while the input kept moving.
- A falling strobe must not load data. A design that captured on any change would take the new input.
- The value held after the pass enable drops must be the last one passed through. A design that cleared the store, or took the value one cycle later, would show the wrong word.
- The idle direction is checked after the other direction is exercised. This catches crossed control wiring.
- A floating input is checked, to expose a missing or wrongly loaded keeper.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef struct packed {
        logic le;
        logic stb;
        logic oe;
    } ctrl_bits_t;

    typedef enum logic [1:0] {
        PATH_HOLD    = 2'd0,
        PATH_PASS    = 2'd1,
        PATH_CAPTURE = 2'd2
    } path_mode_t;

endpackage

// File: rtl/xcvr_ctrl_sync.sv
module xcvr_ctrl_sync
    import xcvr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic le_raw,
    input  logic stb_raw,
    input  logic oe_raw,
    output logic le_s,
    output logic stb_rise,
    output logic oe_s
);

    typedef struct packed {
        ctrl_bits_t [STAGES-1:0] chain;
        logic                    stb_prev;
    } sync_state_t;

    sync_state_t st_d, st_q;
    ctrl_bits_t  tail;

    always_comb begin
        st_d = st_q;
        st_d.chain[0].le  = le_raw;
        st_d.chain[0].stb = stb_raw;
        st_d.chain[0].oe  = oe_raw;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.stb_prev = st_q.chain[STAGES-1].stb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tail     = st_q.chain[STAGES-1];
    assign le_s     = tail.le;
    assign oe_s     = tail.oe;
    assign stb_rise = tail.stb & ~st_q.stb_prev;

endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
    parameter int WIDTH  = 18,
    parameter bit ENABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] bus_in,
    input  logic             driven,
    output logic [WIDTH-1:0] eff
);

    typedef struct packed {
        logic [WIDTH-1:0] kept;
    } keep_state_t;

    keep_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (driven) begin
            st_d.kept = bus_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (ENABLE) begin : g_keep
            assign eff = driven ? bus_in : st_q.kept;
        end else begin : g_float
            assign eff = driven ? bus_in : '0;
        end
    endgenerate

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             le_s,
    input  logic             stb_rise,
    input  logic             oe_s,
    output logic [WIDTH-1:0] dout,
    output logic             drive
);

    typedef struct packed {
        logic [WIDTH-1:0] store;
        logic             drive;
    } path_state_t;

    path_state_t st_d, st_q;
    path_mode_t  mode;

    always_comb begin
        st_d = st_q;
        if (le_s) begin
            mode = PATH_PASS;
        end else if (stb_rise) begin
            mode = PATH_CAPTURE;
        end else begin
            mode = PATH_HOLD;
        end
        case (mode)
            PATH_PASS, PATH_CAPTURE: st_d.store = din;
            default:                 st_d.store = st_q.store;
        endcase
        st_d.drive = oe_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout  = st_q.store;
    assign drive = st_q.drive;

endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
    parameter int WIDTH       = 18,
    parameter int SYNC_STAGES = 2,
    parameter bit KEEPER      = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic             a_driven,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive,
    input  logic [WIDTH-1:0] b_in,
    input  logic             b_driven,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drive,
    input  logic             ab_oe,
    input  logic             ab_le,
    input  logic             ab_stb,
    input  logic             ba_oe,
    input  logic             ba_le,
    input  logic             ba_stb
);

    logic [WIDTH-1:0] a_eff, b_eff;
    logic ab_le_s, ab_rise, ab_oe_s;
    logic ba_le_s, ba_rise, ba_oe_s;

    xcvr_keeper #(.WIDTH(WIDTH), .ENABLE(KEEPER)) u_keep_a (
        .clk(clk), .rst_n(rst_n), .bus_in(a_in), .driven(a_driven), .eff(a_eff)
    );

    xcvr_keeper #(.WIDTH(WIDTH), .ENABLE(KEEPER)) u_keep_b (
        .clk(clk), .rst_n(rst_n), .bus_in(b_in), .driven(b_driven), .eff(b_eff)
    );

    xcvr_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync_ab (
        .clk(clk), .rst_n(rst_n), .le_raw(ab_le), .stb_raw(ab_stb), .oe_raw(ab_oe),
        .le_s(ab_le_s), .stb_rise(ab_rise), .oe_s(ab_oe_s)
    );

    xcvr_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync_ba (
        .clk(clk), .rst_n(rst_n), .le_raw(ba_le), .stb_raw(ba_stb), .oe_raw(ba_oe),
        .le_s(ba_le_s), .stb_rise(ba_rise), .oe_s(ba_oe_s)
    );

    xcvr_path #(.WIDTH(WIDTH)) u_path_ab (
        .clk(clk), .rst_n(rst_n), .din(a_eff), .le_s(ab_le_s), .stb_rise(ab_rise),
        .oe_s(ab_oe_s), .dout(b_out), .drive(b_drive)
    );

    xcvr_path #(.WIDTH(WIDTH)) u_path_ba (
        .clk(clk), .rst_n(rst_n), .din(b_eff), .le_s(ba_le_s), .stb_rise(ba_rise),
        .oe_s(ba_oe_s), .dout(a_out), .drive(a_drive)
    );

endmodule

// File: rtl/bus_xcvr_checker.sv
module bus_xcvr_checker #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic             a_driven,
    input logic [WIDTH-1:0] a_eff,
    input logic [WIDTH-1:0] b_eff,
    input logic             ab_le_s,
    input logic             ab_rise,
    input logic             ab_oe_s,
    input logic             ba_le_s,
    input logic             ba_oe_s,
    input logic [WIDTH-1:0] a_out,
    input logic             a_drive,
    input logic [WIDTH-1:0] b_out,
    input logic             b_drive
);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (b_out == '0 && !b_drive && a_out == '0 && !a_drive));

    a_r2_pass_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le_s |=> b_out == $past(a_eff));

    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le_s && !ab_rise) |=> $stable(b_out));

    a_r4_capture_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le_s && ab_rise) |=> b_out == $past(a_eff));

    a_r7_drive_on: assert property (@(posedge clk) disable iff (!rst_n)
        ab_oe_s |=> b_drive);

    a_r7_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ba_oe_s |=> !a_drive);

    a_r8_ba_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le_s |=> a_out == $past(b_eff));

    a_r9_keeper: assert property (@(posedge clk) disable iff (!rst_n)
        a_driven |=> (!a_driven |-> a_eff == $past(a_in)));

endmodule

bind bus_xcvr bus_xcvr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_driven(a_driven),
    .a_eff(a_eff), .b_eff(b_eff),
    .ab_le_s(ab_le_s), .ab_rise(ab_rise), .ab_oe_s(ab_oe_s),
    .ba_le_s(ba_le_s), .ba_oe_s(ba_oe_s),
    .a_out(a_out), .a_drive(a_drive), .b_out(b_out), .b_drive(b_drive)
);

// File: tb/sim_bus_xcvr.sv
module sim_bus_xcvr;

    localparam int W      = 18;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic a_driven = 1'b1, b_driven = 1'b1;
    logic [W-1:0] a_out, b_out;
    logic a_drive, b_drive;
    logic ab_oe = 1'b0, ab_le = 1'b0, ab_stb = 1'b0;
    logic ba_oe = 1'b0, ba_le = 1'b0, ba_stb = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    bus_xcvr #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_driven(a_driven), .a_out(a_out), .a_drive(a_drive),
        .b_in(b_in), .b_driven(b_driven), .b_out(b_out), .b_drive(b_drive),
        .ab_oe(ab_oe), .ab_le(ab_le), .ab_stb(ab_stb),
        .ba_oe(ba_oe), .ba_le(ba_le), .ba_stb(ba_stb)
    );

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // dir 0: A-to-B, dir 1: B-to-A
    task automatic set_ctl(input bit dir, input logic le, input logic stb, input logic oe);
        if (dir == 1'b0) begin ab_le = le; ab_stb = stb; ab_oe = oe; end
        else             begin ba_le = le; ba_stb = stb; ba_oe = oe; end
    endtask

    task automatic set_src(input bit dir, input logic [W-1:0] v);
        if (dir == 1'b0) a_in = v; else b_in = v;
    endtask

    function automatic logic [W-1:0] far_out(input bit dir);
        return (dir == 1'b0) ? b_out : a_out;
    endfunction

    function automatic logic far_drv(input bit dir);
        return (dir == 1'b0) ? b_drive : a_drive;
    endfunction

    task automatic run_dir(input bit dir, input logic [W-1:0] pat, input logic oe);
        // pass mode
        set_ctl(dir, 1'b1, 1'b0, oe); set_src(dir, pat); settle();
        chk("R2 pass", far_out(dir), pat);
        chk("R7 drive", {{(W-1){1'b0}}, far_drv(dir)}, {{(W-1){1'b0}}, oe});
        // strobe pulse while passing
        set_ctl(dir, 1'b1, 1'b1, oe); @(negedge clk);
        set_src(dir, ~pat); set_ctl(dir, 1'b1, 1'b0, oe); settle();
        chk("R6 strobe in pass", far_out(dir), ~pat);
        // drop pass enable
        set_ctl(dir, 1'b0, 1'b0, oe); settle();
        chk("R5 keep last passed", far_out(dir), ~pat);
        set_src(dir, pat); settle();
        chk("R3 hold", far_out(dir), ~pat);
        // rising strobe captures
        set_ctl(dir, 1'b0, 1'b1, oe); settle();
        chk("R4 rise capture", far_out(dir), pat);
        set_src(dir, ~pat); settle();
        chk("R3 hold strobe high", far_out(dir), pat);
        // falling strobe does nothing
        set_ctl(dir, 1'b0, 1'b0, oe); settle();
        chk("R4 fall no capture", far_out(dir), pat);
    endtask

    initial begin
        #(PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] held_a;
        logic [W-1:0] keep_val;
        // R1: reset dominates active controls
        ab_le = 1'b1; ab_oe = 1'b1; ba_le = 1'b1; ba_oe = 1'b1;
        a_in = 18'h2A5C3; b_in = 18'h15A3C;
        repeat (4) @(negedge clk);
        chk("R1 b_out", b_out, '0);
        chk("R1 a_out", a_out, '0);
        chk("R1 drives", {{(W-2){1'b0}}, a_drive, b_drive}, '0);
        ab_le = 1'b0; ab_oe = 1'b0; ba_le = 1'b0; ba_oe = 1'b0;
        rst_n = 1'b1;
        settle();

        // preload B-to-A with a known word, then leave it idle
        held_a = 18'h0F0F1;
        run_dir(1'b1, held_a, 1'b1);

        for (int p = 0; p < 8; p++) begin
            logic [W-1:0] pat;
            pat = W'((p + 1) * 40503) ^ W'(p << 11);
            run_dir(1'b0, pat, p[0]);
            chk("R8 idle B-to-A value", a_out, held_a);
            chk("R8 idle B-to-A drive", {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, 1'b1});
        end

        for (int p = 0; p < 4; p++) begin
            logic [W-1:0] pat;
            pat = W'((p + 3) * 21011) ^ W'(p << 5);
            run_dir(1'b1, pat, p[1]);
            held_a = pat;
        end

        // R9: keeper holds last driven value on A
        keep_val = 18'h3C3C3;
        a_driven = 1'b1; a_in = keep_val;
        set_ctl(1'b0, 1'b1, 1'b0, 1'b1); settle();
        chk("R9 driven pass", b_out, keep_val);
        a_driven = 1'b0; a_in = 18'h00001; settle();
        chk("R9 keeper holds", b_out, keep_val);
        a_in = 18'h3FFFF; settle();
        chk("R9 keeper ignores floating bus", b_out, keep_val);
        a_driven = 1'b1; a_in = 18'h12345; settle();
        chk("R9 driven again", b_out, 18'h12345);
        chk("R8 B-to-A untouched", a_out, held_a);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule